// File: doc/BRIEF.md
# Transmit Slot Controller

This block runs the transmit side of a network interface that holds its outgoing frames in a small set of fixed register slots. It does not use a descriptor list in memory. Each slot has a buffer-address register and a command/status register. Software fills in the address first. It then writes the command word, which carries the frame length and a start threshold. That write hands the slot to the hardware.

The controller visits the slots in a fixed rotating order. When the slot whose turn it is has been handed over, the controller reads the frame from memory one 32-bit word at a time. It buffers the words and sends the bytes out on a byte-wide stream, but only after enough data has arrived to meet the threshold. At the end it writes a completion word back into the slot and raises a success or error flag in an interrupt register that software clears by writing ones.

The sequencer has five states:
- `ST_IDLE` waits for the current slot to be queued. It goes to `ST_FILL` for a legal length and to `ST_DONE` for an illegal one.
- `ST_FILL` fetches words. It goes to `ST_SEND` once the threshold is met or the whole frame is buffered.
- `ST_SEND` streams bytes. It goes to `ST_DONE` after the last byte. If the buffer runs dry while words are still owed, it goes to `ST_DRAIN`.
- `ST_DRAIN` waits for the outstanding read to return, then goes to `ST_DONE`.
- `ST_DONE` writes the status back, advances the slot pointer and returns to `ST_IDLE`.

Top module: `tx_desc_mgr`

## Requirements
- R1: After reset every slot status reads 0x00002000, meaning the host-owns bit 13 is set. Every slot address reads 0, the interrupt register reads 0, and `tx_valid` and `mem_rd` are low.
- R2: The register offsets are as follows. Slot i status is at 0x10+4i, slot i address is at 0x20+4i, and the interrupt register is at 0x3C. An address write stores bits 31:2 and reads back with bits 1:0 zero.
- R3: A host write to a slot's status clears bit 13 and queues the slot. The status keeps the length in bits 12:0 and the threshold in bits 21:16, and clears bits 31:22 and 15:14. While a slot is queued or in service, host writes to its status and to its address are ignored.
- R4: Slots are serviced strictly in the order 0,1,2,3,0,... A queued slot whose turn has not come causes no memory read and no output.
- R5: The frame is fetched as ceil(len/4) word reads at the buffer address plus 4k, with at most one read outstanding. Bits 7:0 of each word form the lowest-addressed byte.
- R6: No byte is sent until threshold×32 bytes have been fetched, or until the whole frame has been fetched if that comes first. A threshold of 0 starts sending at once.
- R7: Exactly len bytes are sent, in address order, with `tx_last` marking only the final byte. `tx_byte` and `tx_last` hold while `tx_ready` is low.
- R8: If the buffer is empty during sending while words are still unfetched, the frame stops. Status bit 14 is set, bit 15 stays clear, and interrupt bit 3 is set.
- R9: A length of 0 or above 1792 completes with no memory read. Status bit 30 is set and interrupt bit 3 is set.
- R10: The completion status has the following form:
  - bit 13 is set;
  - bit 15 is set on success;
  - bits 29 and 31 are zero;
  - the length and threshold fields are kept.
  
  A success sets interrupt bit 2, and then the next slot takes its turn.
- R11: Writing ones to the interrupt register clears those bits. A completion flag set in the same cycle as a clear of that bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Register write offset |
| host_wdata | input | 32 | Register write data |
| host_rd_addr | input | 8 | Register read offset |
| host_rd_data | output | 32 | Register read data (combinational) |
| mem_rd | output | 1 | Memory word read request |
| mem_addr | output | 32 | Memory read byte address (word aligned) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_irq | output | 1 | High while any interrupt flag is set |

## Verification
The interrupt register has two writers: the completion of a frame sets a flag, and the host clears flags by writing ones. The bench waits for the final byte's handshake. It then times a clear of both flag bits so that the clear lands in the very cycle the sequencer spends in `ST_DONE`. It judges the outcome by reading the register afterwards: the success flag must still be set. A later ordinary clear must then remove it.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SEND,
        ST_DRAIN,
        ST_DONE
    } tx_state_t;

    localparam int LEN_W    = 13;
    localparam int THR_W    = 6;
    localparam int THR_LSB  = 16;
    localparam int IRQ_OK   = 2;
    localparam int IRQ_ERR  = 3;

    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_ADDR = 8'h20;
    localparam logic [7:0] OFS_IRQ  = 8'h3C;

endpackage

// File: rtl/tx_word_fifo.sv
module tx_word_fifo #(
    parameter int DEPTH = 448
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        push,
    input  logic [31:0] wdata,
    input  logic        pop,
    output logic        empty,
    output logic [31:0] head
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [31:0]   store [2**PW];
    logic [PW-1:0] wptr_q;
    logic [PW-1:0] rptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + 1'b1;
            if (pop)  rptr_q <= rptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wptr_q] <= wdata;
    end

    assign empty = (wptr_q == rptr_q);
    assign head  = store[rptr_q];

endmodule

// File: rtl/tx_slot_regs.sv
module tx_slot_regs
    import tx_desc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [7:0]           host_addr,
    input  logic [31:0]          host_wdata,
    input  logic [7:0]           host_rd_addr,
    output logic [31:0]          host_rd_data,
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic                 done_stb,
    input  logic                 done_ok,
    input  logic                 done_unr,
    input  logic                 done_bad,
    output logic [NUM_SLOTS-1:0] queued,
    output logic [31:0]          cur_addr,
    output logic [LEN_W-1:0]     cur_len,
    output logic [THR_W-1:0]     cur_thr,
    output logic [15:0]          irq_flags
);
    logic [NUM_SLOTS-1:0][31:0] stat_all;
    logic [NUM_SLOTS-1:0][31:0] addr_all;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [31:0] stat_r;
        logic [31:0] addr_r;
        logic        q_r;
        wire hit_stat = host_wr && (host_addr == OFS_STAT + 8'(4 * i));
        wire hit_addr = host_wr && (host_addr == OFS_ADDR + 8'(4 * i));
        wire fin      = done_stb && (cur_slot == SLOT_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_r <= 32'h0000_2000;
                addr_r <= '0;
                q_r    <= 1'b0;
            end else if (fin) begin
                stat_r <= {1'b0, done_bad, 1'b0, 7'b0, stat_r[21:16],
                           done_ok, done_unr, 1'b1, stat_r[12:0]};
                q_r    <= 1'b0;
            end else if (!q_r) begin
                if (hit_stat) begin
                    stat_r <= {10'b0, host_wdata[21:16], 3'b000, host_wdata[12:0]};
                    q_r    <= 1'b1;
                end
                if (hit_addr) addr_r <= {host_wdata[31:2], 2'b00};
            end
        end

        assign stat_all[i] = stat_r;
        assign addr_all[i] = addr_r;
        assign queued[i]   = q_r;
    end

    assign cur_addr = addr_all[cur_slot];
    assign cur_len  = stat_all[cur_slot][LEN_W-1:0];
    assign cur_thr  = stat_all[cur_slot][THR_LSB +: THR_W];

    // Completion set wins over a host clear in the same cycle.
    logic [15:0] irq_set;
    logic [15:0] irq_clr;
    always_comb begin
        irq_set = '0;
        if (done_stb) begin
            if (done_ok) irq_set[IRQ_OK]  = 1'b1;
            else         irq_set[IRQ_ERR] = 1'b1;
        end
        irq_clr = (host_wr && host_addr == OFS_IRQ) ? host_wdata[15:0] : 16'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_flags <= '0;
        else        irq_flags <= (irq_flags & ~irq_clr) | irq_set;
    end

    always_comb begin
        host_rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (host_rd_addr == OFS_STAT + 8'(4 * i)) host_rd_data = stat_all[i];
            if (host_rd_addr == OFS_ADDR + 8'(4 * i)) host_rd_data = addr_all[i];
        end
        if (host_rd_addr == OFS_IRQ) host_rd_data = {16'h0, irq_flags};
    end

endmodule

// File: rtl/tx_engine.sv
module tx_engine
    import tx_desc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int MAX_LEN   = 1792
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] queued,
    input  logic [31:0]          cur_addr,
    input  logic [LEN_W-1:0]     cur_len,
    input  logic [THR_W-1:0]     cur_thr,
    output logic [SLOT_W-1:0]    cur_slot,
    output logic                 done_stb,
    output logic                 done_ok,
    output logic                 done_unr,
    output logic                 done_bad,
    output logic                 mem_rd,
    output logic [31:0]          mem_addr,
    input  logic                 mem_rvalid,
    output logic                 fifo_clr,
    output logic                 fifo_push,
    output logic                 fifo_pop,
    input  logic                 fifo_empty,
    input  logic [31:0]          fifo_head,
    output logic                 tx_valid,
    output logic [7:0]           tx_byte,
    output logic                 tx_last,
    input  logic                 tx_ready
);
    localparam int WC_W = $clog2(MAX_LEN / 4 + 1);

    tx_state_t         st_q, st_nx;
    logic [LEN_W-1:0]  len_q;
    logic [THR_W-1:0]  thr_q;
    logic [31:0]       base_q;
    logic [WC_W-1:0]   wreq_q, wgot_q;
    logic [LEN_W-1:0]  sent_q;
    logic [1:0]        lane_q;
    logic              pend_q, unr_q, bad_q;
    logic [SLOT_W-1:0] cur_q;

    wire              len_bad  = (cur_len == '0) || (cur_len > LEN_W'(MAX_LEN));
    wire [LEN_W-1:0]  len_rnd  = len_q + LEN_W'(3);
    wire [WC_W-1:0]   tot_w    = WC_W'(len_rnd >> 2);
    wire              all_in   = (wgot_q == tot_w);
    wire              thr_met  = ((16'(wgot_q) << 2) >= (16'(thr_q) << 5));
    wire              hs       = tx_valid && tx_ready;
    wire              starve   = (st_q == ST_SEND) && fifo_empty && !all_in;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:  if (queued[cur_q]) st_nx = len_bad ? ST_DONE : ST_FILL;
            ST_FILL:  if (thr_met || all_in) st_nx = ST_SEND;
            ST_SEND:  if (hs && tx_last) st_nx = ST_DONE;
                      else if (starve)   st_nx = ST_DRAIN;
            ST_DRAIN: if (!pend_q || mem_rvalid) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd    = ((st_q == ST_FILL) || (st_q == ST_SEND)) && !pend_q &&
                    (wreq_q != tot_w) && !starve;
        mem_addr  = base_q + (32'(wreq_q) << 2);
        fifo_clr  = (st_q == ST_IDLE);
        fifo_push = pend_q && mem_rvalid;
        tx_valid  = (st_q == ST_SEND) && !fifo_empty;
        tx_byte   = fifo_head[{lane_q, 3'b000} +: 8];
        tx_last   = (sent_q == len_q - LEN_W'(1));
        fifo_pop  = hs && ((lane_q == 2'd3) || tx_last);
        done_stb  = (st_q == ST_DONE);
        done_ok   = !unr_q && !bad_q;
        done_unr  = unr_q;
        done_bad  = bad_q;
        cur_slot  = cur_q;
    end

    // Frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            thr_q  <= '0;
            base_q <= '0;
            wreq_q <= '0;
            wgot_q <= '0;
            sent_q <= '0;
            lane_q <= '0;
            pend_q <= 1'b0;
            unr_q  <= 1'b0;
            bad_q  <= 1'b0;
            cur_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && queued[cur_q]) begin
                len_q  <= cur_len;
                thr_q  <= cur_thr;
                base_q <= cur_addr;
                wreq_q <= '0;
                wgot_q <= '0;
                sent_q <= '0;
                lane_q <= '0;
                unr_q  <= 1'b0;
                bad_q  <= len_bad;
            end
            if (mem_rd)          pend_q <= 1'b1;
            else if (mem_rvalid) pend_q <= 1'b0;
            if (mem_rd)    wreq_q <= wreq_q + 1'b1;
            if (fifo_push) wgot_q <= wgot_q + 1'b1;
            if (hs) begin
                sent_q <= sent_q + 1'b1;
                lane_q <= lane_q + 1'b1;
            end
            if (starve) unr_q <= 1'b1;
            if (st_q == ST_DONE)
                cur_q <= (cur_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : cur_q + 1'b1;
        end
    end

endmodule

// File: rtl/tx_desc_mgr.sv
module tx_desc_mgr
    import tx_desc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int MAX_LEN   = 1792
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    input  logic [7:0]  host_rd_addr,
    output logic [31:0] host_rd_data,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        tx_irq
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int DEPTH  = MAX_LEN / 4;

    logic [NUM_SLOTS-1:0] queued;
    logic [31:0]          cur_addr;
    logic [LEN_W-1:0]     cur_len;
    logic [THR_W-1:0]     cur_thr;
    logic [SLOT_W-1:0]    cur_slot;
    logic                 done_stb, done_ok, done_unr, done_bad;
    logic                 fifo_clr, fifo_push, fifo_pop, fifo_empty;
    logic [31:0]          fifo_head;
    logic [15:0]          irq_flags;

    tx_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .cur_slot(cur_slot), .done_stb(done_stb), .done_ok(done_ok),
        .done_unr(done_unr), .done_bad(done_bad), .queued(queued),
        .cur_addr(cur_addr), .cur_len(cur_len), .cur_thr(cur_thr),
        .irq_flags(irq_flags)
    );

    tx_engine #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .MAX_LEN(MAX_LEN)) u_eng (
        .clk(clk), .rst_n(rst_n), .queued(queued), .cur_addr(cur_addr),
        .cur_len(cur_len), .cur_thr(cur_thr), .cur_slot(cur_slot),
        .done_stb(done_stb), .done_ok(done_ok), .done_unr(done_unr),
        .done_bad(done_bad), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .fifo_clr(fifo_clr), .fifo_push(fifo_push),
        .fifo_pop(fifo_pop), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_ready(tx_ready)
    );

    tx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(fifo_push),
        .wdata(mem_rdata), .pop(fifo_pop), .empty(fifo_empty), .head(fifo_head)
    );

    assign tx_irq = |irq_flags;

endmodule

// File: rtl/tx_desc_mgr_chk.sv
module tx_desc_mgr_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic [31:0]       mem_addr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_byte,
    input logic              tx_last,
    input logic              done_stb,
    input logic [SLOT_W-1:0] cur_slot,
    input logic [15:0]       irq_flags
);
    p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00));

    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

    p_last_completes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> done_stb);

    p_flag_raised_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> (irq_flags[2] || irq_flags[3]));

    p_rr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> (cur_slot == (($past(cur_slot) == SLOT_W'(NUM_SLOTS - 1)) ?
                                   SLOT_W'(0) : $past(cur_slot) + 1'b1)));

endmodule

bind tx_desc_mgr tx_desc_mgr_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .tx_last(tx_last), .done_stb(done_stb), .cur_slot(cur_slot),
    .irq_flags(irq_flags)
);

// File: tb/tx_desc_mgr_test.sv
`timescale 1ns/1ps
module tx_desc_mgr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  host_rd_addr = '0;
    logic [31:0] host_rd_data;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        tx_irq;

    tx_desc_mgr uut (.*);

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    int exp_cur = 0;
    int mem_lat = 1;
    bit bp_on = 1'b0;
    int cyc = 0;
    logic [7:0] rx_q [2048];
    bit         rx_l [2048];
    int rx_n = 0, req_n = 0, resp_n = 0, first_resp = -1;
    bit busy = 1'b0;
    int wait_cnt = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [7:0] bval(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Downstream sink, monitor and memory model, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        tx_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
        if (tx_valid && tx_ready) begin
            rx_q[rx_n] = tx_byte;
            rx_l[rx_n] = tx_last;
            rx_n++;
        end
        if (tx_valid && first_resp < 0) first_resp = resp_n;
        mem_rvalid = 1'b0;
        if (busy) begin
            if (wait_cnt <= 1) begin
                mem_rvalid = 1'b1;
                mem_rdata  = {bval(pend_addr + 3), bval(pend_addr + 2),
                              bval(pend_addr + 1), bval(pend_addr)};
                busy = 1'b0;
                resp_n++;
            end else wait_cnt--;
        end
        if (mem_rd) begin
            req_n++;
            busy = 1'b1;
            pend_addr = mem_addr;
            wait_cnt = mem_lat;
        end
    end

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        host_rd_addr = a;
        #1 d = host_rd_data;
    endtask

    task automatic clear_stats();
        rx_n = 0; req_n = 0; resp_n = 0; first_resp = -1;
    endtask

    task automatic wait_own(input int slot, input string tag);
        logic [31:0] s;
        int n = 0;
        do begin
            @(negedge clk);
            reg_read(8'h10 + 8'(4 * slot), s);
            n++;
        end while (!s[13] && n < 8000);
        chk_eq({tag, " completion reached"}, 32'(s[13]), 32'd1);
    endtask

    task automatic start_frame(input int slot, input logic [31:0] a, input int len, input int thr);
        reg_write(8'h20 + 8'(4 * slot), a);
        reg_write(8'h10 + 8'(4 * slot), (32'(thr) << 16) | 32'(len));
    endtask

    task automatic check_bytes(input string tag, input int from, input logic [31:0] a, input int len);
        int bad = 0;
        for (int k = 0; k < len; k++) begin
            if (rx_q[from + k] !== bval(a + 32'(k))) bad++;
            if (rx_l[from + k] !== (k == len - 1)) bad++;
        end
        chk_eq({tag, " byte/last mismatches"}, 32'(bad), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            reg_read(8'h10 + 8'(4 * i), d); chk_eq("R1 status reset", d, 32'h0000_2000);
            reg_read(8'h20 + 8'(4 * i), d); chk_eq("R1 address reset", d, 32'h0);
        end
        reg_read(8'h3C, d); chk_eq("R1 irq reset", d, 32'h0);
        chk_eq("R1 no output/read", {30'b0, tx_valid, mem_rd}, 32'h0);
        chk_eq("R1 no reads since reset", 32'(req_n), 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reg_write(8'h28, 32'h0000_1237);
        reg_read(8'h28, d); chk_eq("R2 address alignment", d, 32'h0000_1234);
        reg_write(8'h2C, 32'hABCD_0003);
        reg_read(8'h2C, d); chk_eq("R2 slot3 address offset", d, 32'hABCD_0000);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        clear_stats();
        start_frame(exp_cur, 32'h1000, 13, 63);
        reg_read(8'h10 + 8'(4 * exp_cur), d);
        chk_eq("R3 status after handover", d, 32'h003F_000D);
        wait_own(exp_cur, "R10 basic");
        chk_eq("R7 byte count", 32'(rx_n), 32'd13);
        check_bytes("R5 R7 basic", 0, 32'h1000, 13);
        chk_eq("R5 read count", 32'(req_n), 32'd4);
        reg_read(8'h10 + 8'(4 * exp_cur), d);
        chk_eq("R10 success status", d, 32'h003F_A00D);
        reg_read(8'h3C, d); chk_eq("R10 ok flag", d, 32'h4);
        chk_eq("R10 irq line", 32'(tx_irq), 32'd1);
        reg_write(8'h3C, 32'h4);
        reg_read(8'h3C, d); chk_eq("R11 w1c clear", d, 32'h0);
        exp_cur = (exp_cur + 1) % 4;
    endtask

    task automatic t_threshold();
        clear_stats();
        start_frame(exp_cur, 32'h2200, 64, 1);
        wait_own(exp_cur, "R6 thr1");
        chk_eq("R6 words before first byte >= 8", 32'(first_resp >= 8), 32'd1);
        check_bytes("R6 thr1 data", 0, 32'h2200, 64);
        exp_cur = (exp_cur + 1) % 4;
        clear_stats();
        start_frame(exp_cur, 32'h2400, 40, 2);
        wait_own(exp_cur, "R6 thr2");
        chk_eq("R6 whole frame before first byte", 32'(first_resp >= 10), 32'd1);
        check_bytes("R6 thr2 data", 0, 32'h2400, 40);
        exp_cur = (exp_cur + 1) % 4;
        reg_write(8'h3C, 32'hC);
    endtask

    task automatic t_backpressure();
        clear_stats();
        bp_on = 1'b1;
        start_frame(exp_cur, 32'h5001, 30, 63);
        wait_own(exp_cur, "R7 stall");
        bp_on = 1'b0;
        chk_eq("R7 stall byte count", 32'(rx_n), 32'd30);
        check_bytes("R7 stall data", 0, 32'h5000, 30);
        exp_cur = (exp_cur + 1) % 4;
        reg_write(8'h3C, 32'hC);
    endtask

    task automatic t_underrun();
        logic [31:0] d;
        clear_stats();
        mem_lat = 4;
        start_frame(exp_cur, 32'h6000, 20, 0);
        wait_own(exp_cur, "R8 underrun");
        mem_lat = 1;
        chk_eq("R8 no bytes sent", 32'(rx_n), 32'd0);
        reg_read(8'h10 + 8'(4 * exp_cur), d);
        chk_eq("R8 underrun status", d, 32'h0000_6014);
        reg_read(8'h3C, d); chk_eq("R8 error flag", d, 32'h8);
        reg_write(8'h3C, 32'h8);
        exp_cur = (exp_cur + 1) % 4;
    endtask

    task automatic t_badlen();
        logic [31:0] d;
        clear_stats();
        start_frame(exp_cur, 32'h7000, 0, 5);
        wait_own(exp_cur, "R9 zero len");
        reg_read(8'h10 + 8'(4 * exp_cur), d);
        chk_eq("R9 zero length status", d, 32'h4005_2000);
        chk_eq("R9 zero length no read", 32'(req_n), 32'd0);
        reg_read(8'h3C, d); chk_eq("R9 error flag", d, 32'h8);
        reg_write(8'h3C, 32'h8);
        exp_cur = (exp_cur + 1) % 4;
        clear_stats();
        start_frame(exp_cur, 32'h7000, 1793, 0);
        wait_own(exp_cur, "R9 long");
        reg_read(8'h10 + 8'(4 * exp_cur), d);
        chk_eq("R9 oversize status", d, 32'h4000_2701);
        chk_eq("R9 oversize no read/output", 32'(req_n + rx_n), 32'd0);
        reg_write(8'h3C, 32'h8);
        exp_cur = (exp_cur + 1) % 4;
        clear_stats();
        start_frame(exp_cur, 32'h8000, 1792, 63);
        wait_own(exp_cur, "R9 max len");
        reg_read(8'h10 + 8'(4 * exp_cur), d);
        chk_eq("R9 max length accepted", d, 32'h003F_A700);
        chk_eq("R9 max length byte count", 32'(rx_n), 32'd1792);
        check_bytes("R9 max length data", 0, 32'h8000, 1792);
        reg_write(8'h3C, 32'hC);
        exp_cur = (exp_cur + 1) % 4;
    endtask

    task automatic t_round_robin();
        logic [31:0] d;
        int c = exp_cur;
        int n = (exp_cur + 1) % 4;
        clear_stats();
        start_frame(n, 32'h3000, 8, 63);
        repeat (20) @(negedge clk);
        chk_eq("R4 out-of-turn slot idle", 32'(req_n + rx_n), 32'd0);
        reg_write(8'h20 + 8'(4 * n), 32'h3500);
        reg_read(8'h20 + 8'(4 * n), d); chk_eq("R3 queued address kept", d, 32'h3000);
        reg_write(8'h10 + 8'(4 * n), 32'h5);
        reg_read(8'h10 + 8'(4 * n), d); chk_eq("R3 queued status kept", d, 32'h003F_0008);
        start_frame(c, 32'h2000, 6, 63);
        wait_own(n, "R4 order");
        chk_eq("R4 total bytes", 32'(rx_n), 32'd14);
        check_bytes("R4 current slot first", 0, 32'h2000, 6);
        check_bytes("R4 next slot second", 6, 32'h3000, 8);
        reg_write(8'h3C, 32'hC);
        exp_cur = (exp_cur + 2) % 4;
    endtask

    task automatic t_irq_race();
        logic [31:0] d;
        int n = 0;
        clear_stats();
        reg_write(8'h3C, 32'hC);
        start_frame(exp_cur, 32'h4000, 4, 63);
        do begin
            @(negedge clk);
            n++;
        end while (!(tx_valid && tx_last) && n < 2000);
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'h3C; host_wdata = 32'hC;
        @(negedge clk);
        host_wr = 1'b0;
        reg_read(8'h3C, d); chk_eq("R11 set wins over clear", d, 32'h4);
        wait_own(exp_cur, "R11 race");
        reg_write(8'h3C, 32'h4);
        reg_read(8'h3C, d); chk_eq("R11 later clear", d, 32'h0);
        exp_cur = (exp_cur + 1) % 4;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_threshold();
        t_backpressure();
        t_underrun();
        t_badlen();
        t_round_robin();
        t_irq_race();
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule